// File: doc/BRIEF.md
# Four-Lane Interleaved AES-128 Encryption Core

This core encrypts four independent 128-bit blocks under one AES-128 key using a single shared round datapath. The datapath is a ring of four registered stages: byte substitution, row rotation, column mixing and round-key addition. Each stage takes exactly one clock. Four blocks circulate through the ring at once, so on every cycle each stage is working on a different block. Each block carries a tag that holds its lane number and its round count. The tag selects the round key the block needs and the output slice that receives its result.

A transfer carries 512 bits, which is four blocks. Lane i occupies bits [128*i+127 : 128*i]. Inside a block, bits [127:120] are state byte 0, and the state is filled column by column (byte index = 4*column + row). The accepted word is buffered. Its lanes then enter the ring one per cycle, lane 0 first. Finished lanes are gathered one per cycle into a 512-bit output register.

Round keys are held outside the core. The core drives a round index on `rk_round` and expects the matching 128-bit key on `rk_key` combinationally in the same cycle. Index 0 is the initial whitening key and index 10 is the key for the final round.

Input handshake rules:
- A transfer is taken on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` stays low from the accepting edge until the result has been handed over.
- `in_valid` is ignored while `in_ready` is low.

Output handshake rules:
- `out_valid` and `out_blocks` hold until a rising edge where `out_ready` is high.
- The core is ready again in the next cycle.

Top module: `aes4_interleave_core`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Every lane gives the AES-128 ciphertext of its plaintext. This means whitening with key 0, then rounds 1 to 9 (substitution, row rotation by 0/1/2/3 bytes left for rows 0 to 3, column mixing, key XOR), then round 10 without column mixing. With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, every lane gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R3: Four different plaintexts in one transfer each produce their own ciphertext, in their own output slice.
- R4: `out_valid` rises on the 43rd rising edge after the accepting edge, which is 4*ROUNDS + LANES - 1 edges.
- R5: The `rk_round` index never exceeds ROUNDS. A block uses key k for the key addition of round k.
- R6: `in_ready` is low from the accepting edge until the output handshake. A held `in_valid` during that time with other data changes neither the result nor starts a second transfer.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_blocks` stay unchanged.
- R8: After the output handshake edge, `out_valid` is 0 and `in_ready` is 1.
- R9: The substitution is correct for all 256 byte values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Core idle and able to take a transfer |
| in_blocks | input | 512 | Four plaintext blocks, lane i in bits 128*i+127:128*i |
| out_valid | output | 1 | Four ciphertext blocks available |
| out_ready | input | 1 | Consumer takes the output |
| out_blocks | output | 512 | Four ciphertext blocks, same lane layout |
| rk_round | output | 4 | Round index of the key wanted this cycle |
| rk_key | input | 128 | Round key for `rk_round`, same cycle |

## Verification
The bench builds the core with its default parameters: ten rounds and four lanes.

This configuration brings the following within reach:
- The published single-block vectors can be checked literally in every lane.
- Four transfers whose plaintext bytes together cover 0 to 255 drive every substitution entry through a real encryption.
- Transfers with distinct lanes show that the lane tags steer each result to its own slice.

Expected ciphertexts come from a separate model in the bench. Its substitution table is built from exponent and logarithm tables, not from the design's inversion-by-power approach. The bench also varies output stalls and holds `in_valid` during a run.

// File: rtl/aes_pkg.sv
`timescale 1ns/1ps
package aes_pkg;
  localparam int LANES   = 4;
  localparam int BLK_W   = 128;
  localparam int LANE_IW = $clog2(LANES);
  localparam int RND_W   = 4;

  typedef logic [BLK_W-1:0] blk_t;

  typedef struct packed {
    logic               vld;
    logic [LANE_IW-1:0] lane;
    logic [RND_W-1:0]   rnd;
  } tag_t;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, aa;
    p  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = gf_x2(aa);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  // multiplicative inverse as x^254, followed by the affine map
  function automatic logic [7:0] sbox_entry(input logic [7:0] x);
    logic [7:0] r, sq;
    r  = 8'h01;
    sq = x;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r ^ rotl8(r, 1) ^ rotl8(r, 2) ^ rotl8(r, 3) ^ rotl8(r, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sub_stage.sv
`timescale 1ns/1ps
module aes_sub_stage import aes_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  blk_t d,
  input  tag_t t_in,
  output blk_t q,
  output tag_t t_q
);
  logic [7:0] rom [256];
  blk_t       nxt;

  for (genvar i = 0; i < 256; i++) begin : g_rom
    assign rom[i] = sbox_entry(8'(i));
  end

  for (genvar k = 0; k < BLK_W / 8; k++) begin : g_look
    assign nxt[8*k +: 8] = rom[d[8*k +: 8]];
  end

  always_ff @(posedge clk) q <= nxt;

  // the round count advances here: downstream stages see the round being built
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        t_q <= '0;
    else if (t_in.vld) t_q <= tag_t'{vld: 1'b1, lane: t_in.lane, rnd: t_in.rnd + 1'b1};
    else               t_q <= '0;
  end
endmodule

// File: rtl/aes_shift_stage.sv
`timescale 1ns/1ps
module aes_shift_stage import aes_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  blk_t d,
  input  tag_t t_in,
  output blk_t q,
  output tag_t t_q
);
  blk_t nxt;

  // byte (row r, column c) takes the byte of row r from column (c+r) mod 4
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign nxt[BLK_W-1-8*(4*c+r) -: 8] = d[BLK_W-1-8*(4*((c+r)%4)+r) -: 8];
    end
  end

  always_ff @(posedge clk) q <= nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_in;
  end
endmodule

// File: rtl/aes_mix_stage.sv
`timescale 1ns/1ps
module aes_mix_stage import aes_pkg::*; #(
  parameter int ROUNDS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  blk_t d,
  input  tag_t t_in,
  output blk_t q,
  output tag_t t_q
);
  blk_t mixed;

  for (genvar c = 0; c < 4; c++) begin : g_col
    logic [7:0] s0, s1, s2, s3;
    assign s0 = d[BLK_W-1-32*c      -: 8];
    assign s1 = d[BLK_W-1-32*c-8    -: 8];
    assign s2 = d[BLK_W-1-32*c-16   -: 8];
    assign s3 = d[BLK_W-1-32*c-24   -: 8];
    assign mixed[BLK_W-1-32*c    -: 8] = gf_x2(s0) ^ gf_x2(s1) ^ s1 ^ s2 ^ s3;
    assign mixed[BLK_W-1-32*c-8  -: 8] = s0 ^ gf_x2(s1) ^ gf_x2(s2) ^ s2 ^ s3;
    assign mixed[BLK_W-1-32*c-16 -: 8] = s0 ^ s1 ^ gf_x2(s2) ^ gf_x2(s3) ^ s3;
    assign mixed[BLK_W-1-32*c-24 -: 8] = gf_x2(s0) ^ s0 ^ s1 ^ s2 ^ gf_x2(s3);
  end

  // the last round passes through, keeping the slot timing unchanged
  always_ff @(posedge clk) q <= (t_in.rnd == RND_W'(ROUNDS)) ? d : mixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_q <= '0;
    else        t_q <= t_in;
  end
endmodule

// File: rtl/aes_key_stage.sv
`timescale 1ns/1ps
module aes_key_stage import aes_pkg::*; #(
  parameter int ROUNDS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               feed_vld,
  input  logic [LANE_IW-1:0] feed_lane,
  input  blk_t               feed_blk,
  input  blk_t               d,
  input  tag_t               t_in,
  input  blk_t               rk_key,
  output logic [RND_W-1:0]   rk_round,
  output logic               retire,
  output logic [LANE_IW-1:0] retire_lane,
  output blk_t               res,
  output blk_t               q,
  output tag_t               t_q
);
  tag_t src_tag;
  blk_t src_blk;

  // new plaintext enters as round 0; otherwise the mixed block returns
  assign src_tag  = feed_vld ? tag_t'{vld: 1'b1, lane: feed_lane, rnd: '0} : t_in;
  assign src_blk  = feed_vld ? feed_blk : d;
  assign rk_round = src_tag.rnd;
  assign res      = src_blk ^ rk_key;

  assign retire      = src_tag.vld && (src_tag.rnd == RND_W'(ROUNDS));
  assign retire_lane = src_tag.lane;

  always_ff @(posedge clk) q <= res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       t_q <= '0;
    else if (src_tag.vld && !retire)  t_q <= src_tag;
    else                              t_q <= '0;
  end
endmodule

// File: rtl/aes4_interleave_core.sv
`timescale 1ns/1ps
module aes4_interleave_core import aes_pkg::*; #(
  parameter int ROUNDS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*BLK_W-1:0] in_blocks,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*BLK_W-1:0] out_blocks,
  output logic [RND_W-1:0]       rk_round,
  input  logic [BLK_W-1:0]       rk_key
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} state_t;

  state_t             state;
  logic               accept;
  logic               loading;
  logic [LANE_IW-1:0] load_lane;
  logic [LANE_IW-1:0] ret_cnt;
  blk_t               buf_r [LANES];
  blk_t               out_r [LANES];

  logic               feed_vld;
  logic [LANE_IW-1:0] feed_lane;
  blk_t               feed_blk;

  blk_t key_q, sub_q, shf_q, mix_q, res;
  tag_t key_t, sub_t, shf_t, mix_t;
  logic               retire;
  logic [LANE_IW-1:0] retire_lane;

  assign accept    = in_valid && (state == ST_IDLE);
  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);

  // input selector: lane 0 straight from the port, then lanes 1..3 from the buffer
  assign feed_vld  = accept || loading;
  assign feed_lane = accept ? '0 : load_lane;
  assign feed_blk  = accept ? in_blocks[BLK_W-1:0] : buf_r[load_lane];

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int l = 0; l < LANES; l++) buf_r[l] <= in_blocks[BLK_W*l +: BLK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      loading   <= 1'b0;
      load_lane <= '0;
      ret_cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_RUN;
          loading   <= 1'b1;
          load_lane <= LANE_IW'(1);
          ret_cnt   <= '0;
        end
        ST_RUN: begin
          if (loading) begin
            if (load_lane == LANE_IW'(LANES - 1)) loading <= 1'b0;
            load_lane <= load_lane + 1'b1;
          end
          if (retire) begin
            ret_cnt <= ret_cnt + 1'b1;
            if (ret_cnt == LANE_IW'(LANES - 1)) state <= ST_HOLD;
          end
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // output distributor: each finished block lands in the slice named by its tag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++) out_r[l] <= '0;
    end else if (retire) begin
      for (int l = 0; l < LANES; l++) begin
        if (retire_lane == LANE_IW'(l)) out_r[l] <= res;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign out_blocks[BLK_W*l +: BLK_W] = out_r[l];
  end

  aes_key_stage #(.ROUNDS(ROUNDS)) u_key (
    .clk(clk), .rst_n(rst_n),
    .feed_vld(feed_vld), .feed_lane(feed_lane), .feed_blk(feed_blk),
    .d(mix_q), .t_in(mix_t), .rk_key(rk_key), .rk_round(rk_round),
    .retire(retire), .retire_lane(retire_lane), .res(res),
    .q(key_q), .t_q(key_t)
  );

  aes_sub_stage u_sub (
    .clk(clk), .rst_n(rst_n), .d(key_q), .t_in(key_t), .q(sub_q), .t_q(sub_t)
  );

  aes_shift_stage u_shf (
    .clk(clk), .rst_n(rst_n), .d(sub_q), .t_in(sub_t), .q(shf_q), .t_q(shf_t)
  );

  aes_mix_stage #(.ROUNDS(ROUNDS)) u_mix (
    .clk(clk), .rst_n(rst_n), .d(shf_q), .t_in(shf_t), .q(mix_q), .t_q(mix_t)
  );
endmodule

// File: rtl/aes4_core_chk.sv
`timescale 1ns/1ps
module aes4_core_chk import aes_pkg::*; #(
  parameter int ROUNDS = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*BLK_W-1:0] out_blocks,
  input logic [RND_W-1:0]       rk_round
);
  localparam int LAT = 4 * ROUNDS + LANES - 1;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (in_valid && in_ready)         cnt <= CW'(1);
    else if (cnt != '0 && !out_valid)      cnt <= cnt + 1'b1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> cnt == CW'(LAT + 1));

  assert_key_index_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rk_round <= RND_W'(ROUNDS));

  assert_not_ready_while_holding_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_accept_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_blocks)));

  assert_ready_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
endmodule

bind aes4_interleave_core aes4_core_chk #(.ROUNDS(ROUNDS)) u_chk (.*);

// File: tb/sim_aes4_interleave_core.sv
`timescale 1ns/1ps
module sim_aes4_interleave_core;
  localparam int NR    = 10;
  localparam int EXP_N = 4 * NR + 4;   // negedges counted from the accepting edge

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_blocks = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [511:0] out_blocks;
  logic [3:0]   rk_round;
  logic [127:0] rk_key;

  logic [127:0] rk [0:NR];
  logic [7:0]   sb [256];
  int           checks = 0;
  int           failures = 0;
  bit           ended = 0;
  logic [511:0] last_out;

  always #10 clk = ~clk;

  assign rk_key = rk[rk_round];

  aes4_interleave_core #(.ROUNDS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_blocks(in_blocks), .out_valid(out_valid), .out_ready(out_ready),
    .out_blocks(out_blocks), .rk_round(rk_round), .rk_key(rk_key)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  // table built from powers of the generator 3
  task automatic build_sbox();
    logic [7:0] ex [256];
    int         lg [256];
    logic [7:0] inv, v;
    ex[0] = 8'h01;
    for (int i = 1; i < 256; i++) ex[i] = ex[i-1] ^ xt(ex[i-1]);
    for (int i = 0; i < 255; i++) lg[ex[i]] = i;
    for (int x = 0; x < 256; x++) begin
      inv = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      v = 8'h63;
      for (int b = 0; b < 8; b++)
        v[b] = v[b] ^ inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8];
      sb[x] = v;
    end
  endtask

  task automatic set_key(input logic [127:0] k);
    logic [31:0] w [0:4*NR+3];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 4*(NR+1); i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= NR; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] u [16];
    logic [127:0] v;
    v = pt ^ rk[0];
    for (int r = 1; r <= NR; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[v[127-8*i -: 8]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) u[4*c+w] = s[4*((c+w)%4)+w];
      if (r < NR) begin
        for (int c = 0; c < 4; c++) begin
          s[4*c]   = xt(u[4*c]) ^ xt(u[4*c+1]) ^ u[4*c+1] ^ u[4*c+2] ^ u[4*c+3];
          s[4*c+1] = u[4*c] ^ xt(u[4*c+1]) ^ xt(u[4*c+2]) ^ u[4*c+2] ^ u[4*c+3];
          s[4*c+2] = u[4*c] ^ u[4*c+1] ^ xt(u[4*c+2]) ^ xt(u[4*c+3]) ^ u[4*c+3];
          s[4*c+3] = xt(u[4*c]) ^ u[4*c] ^ u[4*c+1] ^ u[4*c+2] ^ xt(u[4*c+3]);
        end
      end else begin
        for (int i = 0; i < 16; i++) s[i] = u[i];
      end
      for (int i = 0; i < 16; i++) v[127-8*i -: 8] = s[i];
      v = v ^ rk[r];
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [511:0] pt, input int stall, input bit poke, input string req);
    logic [511:0] exp_v;
    int n;
    for (int l = 0; l < 4; l++) exp_v[128*l +: 128] = ref_enc(pt[128*l +: 128]);
    @(negedge clk);
    in_blocks = pt;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = poke;
    if (poke) in_blocks = ~pt;
    chk(!in_ready, "R6", 512'(in_ready), 512'(0));
    n = 1;
    while (!out_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    chk(n == EXP_N, "R4", 512'(n), 512'(EXP_N));
    for (int l = 0; l < 4; l++)
      chk(out_blocks[128*l +: 128] == exp_v[128*l +: 128], req,
          512'(out_blocks[128*l +: 128]), 512'(exp_v[128*l +: 128]));
    last_out = out_blocks;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_blocks == exp_v, "R7", out_blocks, exp_v);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R8", 512'({out_valid, in_ready}), 512'(2'b01));
    if (poke) begin
      repeat (60) @(negedge clk);
      chk(!out_valid && in_ready, "R6", 512'({out_valid, in_ready}), 512'(2'b01));
    end
  endtask

  initial begin
    logic [511:0] pt;
    logic [127:0] lf;
    build_sbox();
    set_key(128'h000102030405060708090a0b0c0d0e0f);
    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R1", 512'({in_ready, out_valid}), 512'(2'b10));
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1", 512'({in_ready, out_valid}), 512'(2'b10));

    // published vector in all four lanes
    run_xfer({4{128'h00112233445566778899aabbccddeeff}}, 3, 1'b0, "R2");
    for (int l = 0; l < 4; l++)
      chk(last_out[128*l +: 128] == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2",
          512'(last_out[128*l +: 128]), 512'(128'h69c4e0d86a7b0430d8cdb78070b4c55a));

    // second key, four distinct plaintexts, held in_valid while busy
    set_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    run_xfer({128'h00000000000000000000000000000001, 128'hffffffffffffffffffffffffffffffff,
              128'h00112233445566778899aabbccddeeff, 128'h3243f6a8885a308d313198a2e0370734},
             2, 1'b1, "R3");
    chk(last_out[127:0] == 128'h3925841d02dc09fbdc118597196a0b32, "R2",
        512'(last_out[127:0]), 512'(128'h3925841d02dc09fbdc118597196a0b32));

    // every byte value 0..255 as plaintext input to substitution in round 1 (key 0 zero)
    set_key(128'h0);
    for (int t = 0; t < 4; t++) begin
      for (int l = 0; l < 4; l++)
        for (int b = 0; b < 16; b++) pt[128*l + 127 - 8*b -: 8] = 8'(64*t + 16*l + b);
      run_xfer(pt, t, 1'b0, "R9");
    end

    // pseudo-random lanes, back to back
    set_key(128'hc0ffee0123456789abcdef0011223344);
    lf = 128'h1;
    for (int t = 0; t < 4; t++) begin
      for (int l = 0; l < 4; l++) begin
        for (int k = 0; k < 37; k++) lf = {lf[126:0], lf[127] ^ lf[125] ^ lf[100] ^ lf[98]};
        pt[128*l +: 128] = lf;
      end
      run_xfer(pt, 0, 1'b0, "R3");
    end

    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule